// File: doc/BRIEF.md
# Flash program/erase command timer

This block sequences program and erase operations for an on-chip flash array. A write-once divider register sets a slow timing clock, derived from the bus clock, that the block uses as its unit of time. Software writes an address, a data byte and then a command code. The block raises a high-voltage enable for the array and holds it for a fixed number of timing-clock periods, which depends on the command. The array sees only this enable, the operation code, the address and the data.

Four commands exist: single byte program, burst byte program, page erase and mass erase. A page erase targets the address rounded down to its page boundary. A mass erase presents address zero. Burst programs can be chained. A burst command written while a program pulse is running is held in a one-entry buffer. It then continues the pulse with the short burst count and pays no start or stop overhead.

A command that breaks the rules sets a sticky access-error flag and does not start. Software clears that flag by writing a one to it. The divider value is chosen so that the timing clock falls between 150 kHz and 200 kHz. The block does not enforce that range.

Top module: `flt_cmd_timer`

## Requirements
- R1: After reset, hv_en=0, cmd_done=1, buf_empty=1, acc_err=0, div_locked=0 and div_value=0.
- R2: A command write (bus_sel=3) made before the divider is locked sets acc_err and does not raise hv_en.
- R3: The first divider write (bus_sel=0, bits 6:0) locks the divider (div_locked=1). Every later divider write leaves div_value unchanged.
- R4: A divider write made while acc_err=1 is ignored and does not lock the divider.
- R5: With a divider value in which bit 6 is the prescale flag and bits 5:0 are d, one timing period is P=(d+1)*(bit6 ? 8 : 1) bus cycles. A byte program (code 0) holds hv_en high for exactly 9*P cycles.
- R6: A burst program (code 1) started from idle lasts 9 periods. A burst command written during a running program pulse continues that pulse with no gap for 4 more periods, using the address (bus_sel=1) and data (bus_sel=2) written before it.
- R7: A page erase (code 2) lasts 4000 periods and drives arr_addr with its low 9 bits cleared (512-byte page).
- R8: A mass erase (code 3) lasts 20000 periods and drives arr_addr=0.
- R9: A command that is not a burst continuation, written while hv_en=1, sets acc_err. The running pulse keeps its operation and its length.
- R10: Writing bus_sel=4 with bit 0 set clears acc_err. Writing bit 0 clear leaves it set.
- R11: cmd_done falls on the edge that accepts a command and rises on the same edge on which hv_en falls.
- R12: buf_empty is 0 while a burst continuation waits, and returns to 1 when that continuation takes over the pulse.
- R13: A burst command written after the previous pulse has completed pays the full 9 periods.
- R14: While acc_err=1, command writes are ignored and do not raise hv_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select: 0 divider, 1 address, 2 data, 3 command, 4 status |
| bus_wdata | input | 16 | Write data |
| hv_en | output | 1 | High-voltage enable to the array |
| arr_op | output | 2 | Operation code of the running pulse |
| arr_addr | output | 16 | Array address of the running pulse |
| arr_data | output | 8 | Data byte of the running pulse |
| cmd_done | output | 1 | No command in progress |
| buf_empty | output | 1 | Command buffer free |
| acc_err | output | 1 | Sticky access-error flag |
| div_locked | output | 1 | Divider register has been written |
| div_value | output | 7 | Divider register contents |

## Verification
A wrong tick or pulse counter shows as an hv_en width that differs from the expected count of timing periods times P. The bench measures that width to the exact bus cycle, across a sweep of divider and prescale settings. A corrupted lock or error state shows on the next register write: div_value moves, or acc_err fails to rise, within one cycle. A lost or duplicated continuation changes the chained pulse length by 4*P cycles, and an error in the buffer flag shows on buf_empty one cycle after the buffered write.

// File: rtl/flt_pkg.sv
package flt_pkg;
  typedef enum logic [1:0] {
    OP_BYTE  = 2'd0,
    OP_BURST = 2'd1,
    OP_PAGE  = 2'd2,
    OP_MASS  = 2'd3
  } flt_op_e;

  typedef enum logic [2:0] {
    SEL_DIV  = 3'd0,
    SEL_ADDR = 3'd1,
    SEL_DATA = 3'd2,
    SEL_CMD  = 3'd3,
    SEL_STAT = 3'd4
  } flt_sel_e;
endpackage

// File: rtl/flt_tickgen.sv
// Timing-clock generator: one-cycle tick every P bus cycles while enabled.
module flt_tickgen #(
  parameter int DIVF_W = 6
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en,
  input  logic [DIVF_W-1:0] div_val,
  input  logic              pre8,
  output logic              tick
);
  localparam int CNT_W = DIVF_W + 4;

  logic [CNT_W-1:0] cnt_q, cnt_d, base, per_m1;

  always_comb begin
    base   = CNT_W'(div_val) + CNT_W'(1);
    per_m1 = pre8 ? ((base << 3) - CNT_W'(1)) : (base - CNT_W'(1));
    tick   = en && (cnt_q == per_m1);
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/flt_seq.sv
// Command sequencer: acceptance rules, pulse counting, burst chaining.
module flt_seq import flt_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int BYTE_T    = 9,
  parameter int BURST_T   = 4,
  parameter int PAGE_T    = 4000,
  parameter int MASS_T    = 20000,
  parameter int PAGE_BITS = 9
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick,
  input  logic              cmd_req,
  input  flt_op_e           cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              locked,
  input  logic              err,
  output logic              err_set,
  output logic              run,
  output flt_op_e           op,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data,
  output logic              done,
  output logic              pend
);
  localparam int CNT_W = $clog2(MASS_T + 1);

  logic              run_q, run_d, done_q, done_d, pend_q, pend_d;
  flt_op_e           op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d, paddr_q, paddr_d;
  logic [7:0]        data_q, data_d, pdata_q, pdata_d;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d, tlim_q, tlim_d;
  logic              take_idle, cont_ok, last, is_prog;

  function automatic logic [CNT_W-1:0] full_lim(input flt_op_e o);
    case (o)
      OP_PAGE: full_lim = CNT_W'(PAGE_T - 1);
      OP_MASS: full_lim = CNT_W'(MASS_T - 1);
      default: full_lim = CNT_W'(BYTE_T - 1);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] map_addr(input flt_op_e o, input logic [ADDR_W-1:0] a);
    case (o)
      OP_PAGE: map_addr = {a[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      OP_MASS: map_addr = '0;
      default: map_addr = a;
    endcase
  endfunction

  always_comb begin
    is_prog   = (op_q == OP_BYTE) || (op_q == OP_BURST);
    take_idle = cmd_req && !err && locked && !run_q;
    cont_ok   = cmd_req && !err && run_q && is_prog && (cmd_op == OP_BURST) && !pend_q;
    err_set   = cmd_req && !err && !take_idle && !cont_ok;
    last      = run_q && tick && (tcnt_q == tlim_q);

    run_d = run_q;   done_d = done_q;  pend_d = pend_q;
    op_d  = op_q;    addr_d = addr_q;  data_d = data_q;
    paddr_d = paddr_q; pdata_d = pdata_q;
    tcnt_d = tcnt_q; tlim_d = tlim_q;

    if (take_idle) begin
      run_d  = 1'b1;
      done_d = 1'b0;
      op_d   = cmd_op;
      addr_d = map_addr(cmd_op, cmd_addr);
      data_d = cmd_data;
      tcnt_d = '0;
      tlim_d = full_lim(cmd_op);
    end else if (run_q) begin
      if (tick) tcnt_d = tcnt_q + CNT_W'(1);
      if (last) begin
        tcnt_d = '0;
        if (pend_q) begin
          op_d   = OP_BURST;
          addr_d = paddr_q;
          data_d = pdata_q;
          tlim_d = CNT_W'(BURST_T - 1);
          pend_d = 1'b0;
        end else if (cont_ok) begin
          op_d   = OP_BURST;
          addr_d = cmd_addr;
          data_d = cmd_data;
          tlim_d = CNT_W'(BURST_T - 1);
        end else begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end
      end else if (cont_ok) begin
        pend_d  = 1'b1;
        paddr_d = cmd_addr;
        pdata_d = cmd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;  done_q <= 1'b1;  pend_q <= 1'b0;
      op_q  <= OP_BYTE; addr_q <= '0;  data_q <= '0;
      paddr_q <= '0;  pdata_q <= '0;
      tcnt_q <= '0;   tlim_q <= '0;
    end else begin
      run_q <= run_d;  done_q <= done_d;  pend_q <= pend_d;
      op_q  <= op_d;   addr_q <= addr_d;  data_q <= data_d;
      paddr_q <= paddr_d; pdata_q <= pdata_d;
      tcnt_q <= tcnt_d;   tlim_q <= tlim_d;
    end
  end

  assign run  = run_q;
  assign op   = op_q;
  assign addr = addr_q;
  assign data = data_q;
  assign done = done_q;
  assign pend = pend_q;
endmodule

// File: rtl/flt_cmd_timer.sv
// Top: register file, reset synchroniser, tick generator and sequencer.
module flt_cmd_timer import flt_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int BUS_W      = 16,
  parameter int DIVF_W     = 6,
  parameter int BYTE_T     = 9,
  parameter int BURST_T    = 4,
  parameter int PAGE_T     = 4000,
  parameter int MASS_T     = 20000,
  parameter int PAGE_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_sel,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              hv_en,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic              cmd_done,
  output logic              buf_empty,
  output logic              acc_err,
  output logic              div_locked,
  output logic [DIVF_W:0]   div_value
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  localparam int DREG_W    = DIVF_W + 1;

  logic [1:0]        rsync_q;
  logic              rst_ni;
  logic [DREG_W-1:0] div_q, div_d;
  logic              lock_q, lock_d, err_q, err_d;
  logic [ADDR_W-1:0] areg_q, areg_d;
  logic [7:0]        dreg_q, dreg_d;
  logic              cmd_req, err_set, tick, run, pend, done;
  flt_op_e           op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  always_comb begin
    cmd_req = bus_wr && (bus_sel == SEL_CMD);
    div_d = div_q;  lock_d = lock_q;
    areg_d = areg_q; dreg_d = dreg_q;
    err_d = err_q;
    if (bus_wr && (bus_sel == SEL_DIV) && !lock_q && !err_q) begin
      div_d  = bus_wdata[DREG_W-1:0];
      lock_d = 1'b1;
    end
    if (bus_wr && (bus_sel == SEL_ADDR)) areg_d = bus_wdata[ADDR_W-1:0];
    if (bus_wr && (bus_sel == SEL_DATA)) dreg_d = bus_wdata[7:0];
    if (bus_wr && (bus_sel == SEL_STAT) && bus_wdata[0]) err_d = 1'b0;
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; lock_q <= 1'b0; err_q <= 1'b0;
      areg_q <= '0; dreg_q <= '0;
    end else begin
      div_q <= div_d; lock_q <= lock_d; err_q <= err_d;
      areg_q <= areg_d; dreg_q <= dreg_d;
    end
  end

  flt_tickgen #(.DIVF_W(DIVF_W)) u_tick (
    .clk(clk), .rst_ni(rst_ni), .en(run),
    .div_val(div_q[DIVF_W-1:0]), .pre8(div_q[DIVF_W]), .tick(tick)
  );

  flt_seq #(
    .ADDR_W(ADDR_W), .BYTE_T(BYTE_T), .BURST_T(BURST_T),
    .PAGE_T(PAGE_T), .MASS_T(MASS_T), .PAGE_BITS(PAGE_BITS)
  ) u_seq (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .cmd_req(cmd_req),
    .cmd_op(flt_op_e'(bus_wdata[1:0])), .cmd_addr(areg_q), .cmd_data(dreg_q),
    .locked(lock_q), .err(err_q), .err_set(err_set),
    .run(run), .op(op), .addr(arr_addr), .data(arr_data),
    .done(done), .pend(pend)
  );

  assign hv_en      = run;
  assign arr_op     = op;
  assign cmd_done   = done;
  assign buf_empty  = !pend;
  assign acc_err    = err_q;
  assign div_locked = lock_q;
  assign div_value  = div_q;
endmodule

// File: rtl/flt_cmd_timer_chk.sv
module flt_cmd_timer_chk #(
  parameter int ADDR_W    = 16,
  parameter int BUS_W     = 16,
  parameter int DREG_W    = 7,
  parameter int PAGE_BITS = 9
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              bus_wr,
  input logic [2:0]        bus_sel,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              hv_en,
  input logic [1:0]        arr_op,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              cmd_done,
  input logic              buf_empty,
  input logic              acc_err,
  input logic              div_locked,
  input logic [DREG_W-1:0] div_value
);
  a_r11_pulse_not_done: assert property (@(posedge clk) disable iff (!rst_ni)
    hv_en |-> !cmd_done);

  a_r2_refuse_unlocked: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && bus_sel == 3'd3 && !div_locked) |=> (acc_err && !hv_en));

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    div_locked |=> (div_locked && $stable(div_value)));

  a_r4_no_div_in_err: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && bus_sel == 3'd0 && acc_err) |=> $stable(div_value));

  a_r12_pending_in_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    !buf_empty |-> hv_en);

  a_r7_page_aligned: assert property (@(posedge clk) disable iff (!rst_ni)
    (hv_en && arr_op == 2'd2) |-> (arr_addr[PAGE_BITS-1:0] == '0));

  a_r8_mass_addr_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (hv_en && arr_op == 2'd3) |-> (arr_addr == '0));

  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && bus_sel == 3'd4 && bus_wdata[0]) |=> !acc_err);
endmodule

bind flt_cmd_timer flt_cmd_timer_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DREG_W(DREG_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rst_ni(rst_ni), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .hv_en(hv_en), .arr_op(arr_op), .arr_addr(arr_addr),
  .cmd_done(cmd_done), .buf_empty(buf_empty), .acc_err(acc_err),
  .div_locked(div_locked), .div_value(div_value)
);

// File: tb/tb_flt_cmd_timer.sv
module tb_flt_cmd_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_sel;
  logic [15:0] bus_wdata;
  logic        hv_en, cmd_done, buf_empty, acc_err, div_locked;
  logic [1:0]  arr_op;
  logic [15:0] arr_addr;
  logic [7:0]  arr_data;
  logic [6:0]  div_value;

  int checks = 0, failures = 0, hv_cnt = 0, cyc = 0;

  flt_cmd_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .hv_en(hv_en), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_data(arr_data), .cmd_done(cmd_done), .buf_empty(buf_empty),
    .acc_err(acc_err), .div_locked(div_locked), .div_value(div_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (hv_en) hv_cnt <= hv_cnt + 1;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    checks++; failures++;
    $display("FAIL watchdog: actual=%0d cycles expected below %0d", cyc, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_sel = 3'd0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (hv_en) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 hv_en", hv_en, 0);
    chk("R1 cmd_done", cmd_done, 1);
    chk("R1 buf_empty", buf_empty, 1);
    chk("R1 acc_err", acc_err, 0);
    chk("R1 div_locked", div_locked, 0);
    chk("R1 div_value", div_value, 0);

    // R2 command before divider lock
    wr(3'd3, 16'd0);
    chk("R2 acc_err", acc_err, 1);
    chk("R2 hv_en", hv_en, 0);
    // R4 divider write refused while error pending
    wr(3'd0, 16'd5);
    chk("R4 div_locked", div_locked, 0);
    chk("R4 div_value", div_value, 0);
    // R10 write-one-to-clear
    wr(3'd4, 16'd0);
    chk("R10 keep", acc_err, 1);
    wr(3'd4, 16'd1);
    chk("R10 clear", acc_err, 0);
    // R3 write once
    wr(3'd0, 16'd2);
    chk("R3 locked", div_locked, 1);
    chk("R3 value", div_value, 2);
    wr(3'd0, 16'd9);
    chk("R3 second write ignored", div_value, 2);

    // R5 / R11 sweep of divider and prescale for byte program
    for (int pre = 0; pre < 2; pre++) begin
      for (int d = 0; d < 8; d++) begin
        int p;
        p = (d + 1) * (pre != 0 ? 8 : 1);
        do_reset();
        wr(3'd0, 16'(pre * 64 + d));
        wr(3'd1, 16'h0042);
        wr(3'd2, 16'h00C3);
        hv_cnt = 0;
        wr(3'd3, 16'd0);
        chk("R11 done low", cmd_done, 0);
        chk("R5 data", arr_data, 8'hC3);
        wait_idle();
        chk("R5 byte width", hv_cnt, 9 * p);
        chk("R11 done high", cmd_done, 1);
      end
    end

    // R7 page erase
    do_reset();
    wr(3'd0, 16'd0);
    wr(3'd1, 16'h1234);
    hv_cnt = 0;
    wr(3'd3, 16'd2);
    chk("R7 op", arr_op, 2);
    chk("R7 aligned addr", arr_addr, 16'h1200);
    wait_idle();
    chk("R7 width", hv_cnt, 4000);

    // R8 mass erase
    wr(3'd1, 16'hBEEF);
    hv_cnt = 0;
    wr(3'd3, 16'd3);
    chk("R8 addr", arr_addr, 0);
    wait_idle();
    chk("R8 width", hv_cnt, 20000);

    // R6 / R12 burst chaining with P=2
    do_reset();
    wr(3'd0, 16'd1);
    wr(3'd1, 16'h0010);
    wr(3'd2, 16'h00A5);
    hv_cnt = 0;
    wr(3'd3, 16'd1);
    wr(3'd1, 16'h0011);
    wr(3'd2, 16'h005A);
    wr(3'd3, 16'd1);
    chk("R12 buffer full", buf_empty, 0);
    chk("R6 no error", acc_err, 0);
    wait_idle();
    chk("R6 chained width", hv_cnt, (9 + 4) * 2);
    chk("R6 last addr", arr_addr, 16'h0011);
    chk("R6 last data", arr_data, 8'h5A);
    chk("R12 buffer free", buf_empty, 1);

    // R13 burst after completion pays full overhead
    @(negedge clk);
    hv_cnt = 0;
    wr(3'd3, 16'd1);
    wait_idle();
    chk("R13 width", hv_cnt, 9 * 2);

    // R9 / R14 with P=1
    do_reset();
    wr(3'd0, 16'd0);
    hv_cnt = 0;
    wr(3'd3, 16'd0);
    wr(3'd3, 16'd2);
    chk("R9 acc_err", acc_err, 1);
    chk("R9 op kept", arr_op, 0);
    wait_idle();
    chk("R9 width kept", hv_cnt, 9);
    hv_cnt = 0;
    wr(3'd3, 16'd0);
    @(negedge clk);
    chk("R14 ignored", hv_cnt, 0);
    chk("R14 hv_en", hv_en, 0);
    wr(3'd4, 16'd1);
    wr(3'd3, 16'd0);
    chk("R14 accepted after clear", hv_en, 1);
    wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule